// File: doc/BRIEF.md
# Endian-aware bus width converter

This block sits between an internal 32-bit access port and an external memory data bus whose device width is 8, 16 or 32 bits. A request carries an access size (byte, word or longword), a byte address, a byte-order flag, a write flag and, for writes, right-justified data. The block checks the request for alignment. It then splits the request into as many external bus cycles as the device width needs. On each cycle it places the data bytes on the byte lanes that the byte order and the address select, and it raises the strobes of exactly those lanes.

For reads, the bytes returned on the active lanes are gathered into one right-justified result, with the upper bytes cleared. The device is assumed to answer within the same clock as each bus cycle. Wait states, area decoding and DRAM sequencing belong to neighbouring logic.

Top module: `bus_lane_conv`

## Requirements
- R1: A request with size code 3, device width code 3, a word at an odd address, or a longword whose address is not a multiple of 4 is rejected. `err_o` is high for one cycle in the cycle after acceptance, no bus cycle is issued and `done_o` stays low.
- R2: A valid request starts its first bus cycle in the cycle after acceptance. It uses max(1, access bytes / device bytes) consecutive bus cycles. Size codes are 0 byte, 1 word, 2 longword. Width codes are 0 for 8 bits, 1 for 16 bits, 2 for 32 bits.
- R3: The first bus cycle drives the request address on `bus_addr_o`. Each later cycle adds the number of bytes moved per cycle, min(access bytes, device bytes).
- R4: On a 32-bit device with `big_end_i`=1, the byte at address offset o (0..3) uses lane 3-o. Lane 3 is `bus_wdata_o[31:24]` with strobe bit 3, and lane 0 is bits 7:0 with strobe bit 0. The more significant byte of a word or longword goes to the lower address.
- R5: With `big_end_i`=0, the less significant byte goes to the lower address. On a 32-bit device, offset o uses lane o.
- R6: An 8-bit device uses only lane 0. A 16-bit device uses only lanes 1 and 0: an even address maps to lane 1 when big-endian and to lane 0 when little-endian.
- R7: During a write cycle `bus_write_o` is high. Each strobed lane carries its data byte, and every lane without a strobe carries zero.
- R8: After the last bus cycle of a valid request, `done_o` is high for one cycle. For reads, `rdata_o` then holds the value assembled from the strobed lanes, right-justified, with bytes above the access size zero. Unstrobed lanes have no effect.
- R9: `bus_lane_en_o` is zero whenever `bus_valid_o` is low. While `bus_valid_o` is high, it has exactly min(access bytes, device bytes) bits set.
- R10: After reset the block is idle: `req_ready_o`=1, and `bus_valid_o`, `done_o`, `err_o`, `bus_lane_en_o` and `rdata_o` are all zero.
- R11: A request presented while a transfer is in progress (`req_ready_o`=0) is ignored. The running transfer keeps its addresses and cycle count, and no extra bus cycle or error follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | 0 byte, 1 word, 2 longword |
| req_addr_i | input | ADDR_W | Byte address of the access |
| req_wdata_i | input | 32 | Right-justified write data |
| big_end_i | input | 1 | 1 = big-endian, 0 = little-endian for this area |
| dev_width_i | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit device |
| req_ready_o | output | 1 | Idle and able to accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejection pulse |
| rdata_o | output | 32 | Assembled read result |
| bus_valid_o | output | 1 | External bus cycle in progress |
| bus_write_o | output | 1 | Current bus cycle is a write |
| bus_addr_o | output | ADDR_W | Byte address of current bus cycle |
| bus_lane_en_o | output | 4 | Per-lane byte strobes, bit 3 = bits 31:24 |
| bus_wdata_o | output | 32 | Lane-placed write data |
| bus_rdata_i | input | 32 | Data returned by the device |

## Verification
Directed writes of every byte offset and both word offsets on a 32-bit device, in each byte order, pin down the lane choice. A distinct value in each data byte exposes any swapped or mirrored lane. Longword and word transfers to 8- and 16-bit devices in both orders separate the cycle count, the address step and the ordering of bytes across cycles. Reads from a device that fills its unused lanes with a marker byte show whether the gather takes only strobed lanes. Misaligned requests, reserved codes and a request injected mid-transfer show whether rejection and busy-ignore leave the bus untouched.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
    localparam int LANES = 4;
    localparam int LANE_IDX_W = $clog2(LANES);
    localparam int CNT_W = LANE_IDX_W + 1;
    localparam logic [1:0] SIZE_RSV = 2'd3;
    localparam logic [1:0] WID_RSV = 2'd3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    function automatic logic [CNT_W-1:0] bytes_of(input logic [1:0] code);
        return CNT_W'(1) << code;
    endfunction
endpackage

// File: rtl/bwc_plan.sv
module bwc_plan
    import bwc_pkg::*;
(
    input  logic [1:0]            size_i,
    input  logic [1:0]            width_i,
    input  logic [LANE_IDX_W-1:0] addr_lo_i,
    output logic                  bad_o,
    output logic [CNT_W-1:0]      step_o,
    output logic [CNT_W-1:0]      last_o
);
    logic [CNT_W-1:0] acc_bytes;
    logic [CNT_W-1:0] dev_bytes;
    logic [LANE_IDX_W-1:0] acc_mask;

    always_comb begin
        acc_bytes = bytes_of(size_i);
        dev_bytes = bytes_of(width_i);
        acc_mask  = LANE_IDX_W'(acc_bytes - CNT_W'(1));
        bad_o     = (size_i == SIZE_RSV) || (width_i == WID_RSV) ||
                    ((addr_lo_i & acc_mask) != '0);
        step_o    = (acc_bytes < dev_bytes) ? acc_bytes : dev_bytes;
        last_o    = (acc_bytes > dev_bytes) ? ((acc_bytes >> width_i) - CNT_W'(1)) : '0;
    end
endmodule

// File: rtl/bwc_lane_map.sv
module bwc_lane_map
    import bwc_pkg::*;
(
    input  logic                  big_i,
    input  logic [1:0]            width_i,
    input  logic [1:0]            size_i,
    input  logic [LANE_IDX_W-1:0] cur_lo_i,
    input  logic [LANE_IDX_W-1:0] off_i,
    input  logic [CNT_W-1:0]      step_i,
    input  logic [8*LANES-1:0]    wdata_i,
    input  logic [8*LANES-1:0]    bus_rdata_i,
    input  logic [8*LANES-1:0]    acc_i,
    output logic [LANES-1:0]      lane_en_o,
    output logic [8*LANES-1:0]    wlanes_o,
    output logic [8*LANES-1:0]    gather_o
);
    logic [LANE_IDX_W-1:0] dev_mask;
    logic [LANE_IDX_W-1:0] acc_mask;

    always_comb begin
        dev_mask  = LANE_IDX_W'(bytes_of(width_i) - CNT_W'(1));
        acc_mask  = LANE_IDX_W'(bytes_of(size_i) - CNT_W'(1));
        lane_en_o = '0;
        wlanes_o  = '0;
        gather_o  = acc_i;
        for (int k = 0; k < LANES; k++) begin
            logic [LANE_IDX_W-1:0] adr;
            logic [LANE_IDX_W-1:0] amod;
            logic [LANE_IDX_W-1:0] lane;
            logic [LANE_IDX_W-1:0] pos;
            logic [LANE_IDX_W-1:0] sig;
            adr  = cur_lo_i + LANE_IDX_W'(k);
            amod = adr & dev_mask;
            lane = big_i ? (dev_mask - amod) : amod;
            pos  = off_i + LANE_IDX_W'(k);
            sig  = big_i ? (acc_mask - pos) : pos;
            if (CNT_W'(k) < step_i) begin
                lane_en_o[lane]      = 1'b1;
                wlanes_o[lane*8 +: 8] = wdata_i[sig*8 +: 8];
                gather_o[sig*8 +: 8]  = bus_rdata_i[lane*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/bus_lane_conv.sv
module bus_lane_conv
    import bwc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [1:0]        req_size_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [31:0]       req_wdata_i,
    input  logic              big_end_i,
    input  logic [1:0]        dev_width_i,
    output logic              req_ready_o,
    output logic              done_o,
    output logic              err_o,
    output logic [31:0]       rdata_o,
    output logic              bus_valid_o,
    output logic              bus_write_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [3:0]        bus_lane_en_o,
    output logic [31:0]       bus_wdata_o,
    input  logic [31:0]       bus_rdata_i
);
    localparam int DW = 8 * LANES;

    typedef struct packed {
        logic                  busy;
        logic                  done;
        logic                  err;
        logic                  write;
        logic                  big;
        logic [1:0]            size;
        logic [1:0]            width;
        logic [CNT_W-1:0]      beat;
        logic [CNT_W-1:0]      last;
        logic [CNT_W-1:0]      step;
        logic [LANE_IDX_W-1:0] base_lo;
        logic [ADDR_W-1:0]     cur;
        logic [DW-1:0]         wdata;
        logic [DW-1:0]         rdata;
    } conv_state_t;

    conv_state_t st_d, st_q;

    logic                  plan_bad;
    logic [CNT_W-1:0]      plan_step;
    logic [CNT_W-1:0]      plan_last;
    logic [LANES-1:0]      map_en;
    logic [DW-1:0]         map_wdata;
    logic [DW-1:0]         map_gather;
    logic [LANE_IDX_W-1:0] cur_off;
    logic [1:0]            act_width;

    assign cur_off   = st_q.cur[LANE_IDX_W-1:0] - st_q.base_lo;
    assign act_width = st_q.width;

    bwc_plan plan_i (
        .size_i    (req_size_i),
        .width_i   (dev_width_i),
        .addr_lo_i (req_addr_i[LANE_IDX_W-1:0]),
        .bad_o     (plan_bad),
        .step_o    (plan_step),
        .last_o    (plan_last)
    );

    bwc_lane_map map_i (
        .big_i       (st_q.big),
        .width_i     (st_q.width),
        .size_i      (st_q.size),
        .cur_lo_i    (st_q.cur[LANE_IDX_W-1:0]),
        .off_i       (cur_off),
        .step_i      (st_q.step),
        .wdata_i     (st_q.wdata),
        .bus_rdata_i (bus_rdata_i),
        .acc_i       (st_q.rdata),
        .lane_en_o   (map_en),
        .wlanes_o    (map_wdata),
        .gather_o    (map_gather)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        if (!st_q.busy) begin
            if (req_valid_i) begin
                if (plan_bad) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.busy    = 1'b1;
                    st_d.write   = req_write_i;
                    st_d.big     = big_end_i;
                    st_d.size    = req_size_i;
                    st_d.width   = dev_width_i;
                    st_d.beat    = '0;
                    st_d.last    = plan_last;
                    st_d.step    = plan_step;
                    st_d.base_lo = req_addr_i[LANE_IDX_W-1:0];
                    st_d.cur     = req_addr_i;
                    st_d.wdata   = req_wdata_i;
                    st_d.rdata   = '0;
                end
            end
        end else begin
            if (!st_q.write) begin
                st_d.rdata = map_gather;
            end
            if (st_q.beat == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.beat = st_q.beat + CNT_W'(1);
                st_d.cur  = st_q.cur + ADDR_W'(st_q.step);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready_o   = !st_q.busy;
    assign done_o        = st_q.done;
    assign err_o         = st_q.err;
    assign rdata_o       = st_q.rdata;
    assign bus_valid_o   = st_q.busy;
    assign bus_write_o   = st_q.busy && st_q.write;
    assign bus_addr_o    = st_q.cur;
    assign bus_lane_en_o = st_q.busy ? map_en : '0;
    assign bus_wdata_o   = (st_q.busy && st_q.write) ? map_wdata : '0;
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_ready_o,
    input logic              done_o,
    input logic              err_o,
    input logic              bus_valid_o,
    input logic              bus_write_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [3:0]        bus_lane_en_o,
    input logic [31:0]       bus_wdata_o,
    input logic [1:0]        act_width
);
    // R9
    lanes_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_valid_o |-> bus_lane_en_o == 4'b0);

    // R9
    lanes_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_valid_o |-> ($countones(bus_lane_en_o) == 1 || $countones(bus_lane_en_o) == 2 ||
                         $countones(bus_lane_en_o) == 4));

    // R3
    addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_valid_o && $past(bus_valid_o) |->
            bus_addr_o == $past(bus_addr_o) + ADDR_W'($countones($past(bus_lane_en_o))));

    // R1
    reject_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> !bus_valid_o && !done_o && req_ready_o);

    // R6
    narrow8_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_valid_o && act_width == 2'd0 |-> bus_lane_en_o[3:1] == 3'b0);

    // R6
    narrow16_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_valid_o && act_width == 2'd1 |-> bus_lane_en_o[3:2] == 2'b0);

    // R8
    done_after_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !bus_valid_o && $past(bus_valid_o));

    // R11
    write_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_valid_o && $past(bus_valid_o) |-> $stable(bus_write_o));

    for (genvar g = 0; g < 4; g++) begin : g_lane
        // R7
        unused_lane_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !bus_lane_en_o[g] |-> bus_wdata_o[g*8 +: 8] == 8'h00);
    end
endmodule

bind bus_lane_conv bwc_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_ready_o   (req_ready_o),
    .done_o        (done_o),
    .err_o         (err_o),
    .bus_valid_o   (bus_valid_o),
    .bus_write_o   (bus_write_o),
    .bus_addr_o    (bus_addr_o),
    .bus_lane_en_o (bus_lane_en_o),
    .bus_wdata_o   (bus_wdata_o),
    .act_width     (act_width)
);

// File: tb/bus_lane_conv_tb_top.sv
`timescale 1ns/1ps
module bus_lane_conv_tb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          big_end = 1'b1;
    logic [1:0]    dev_width = 2'd2;
    logic          req_ready, done, err, bus_valid, bus_write;
    logic [31:0]   rdata, bus_wdata, bus_rdata;
    logic [AW-1:0] bus_addr;
    logic [3:0]    lane_en;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 0;
    logic [3:0]  first_en;
    logic [31:0] first_wd;
    logic [7:0]  mem [0:255];
    int          cur_w = 4;
    bit          cur_big = 1;

    always #2.5 clk = ~clk;

    bus_lane_conv #(.ADDR_W(AW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
        .req_size_i(req_size), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .big_end_i(big_end), .dev_width_i(dev_width), .req_ready_o(req_ready),
        .done_o(done), .err_o(err), .rdata_o(rdata), .bus_valid_o(bus_valid),
        .bus_write_o(bus_write), .bus_addr_o(bus_addr), .bus_lane_en_o(lane_en),
        .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata)
    );

    // device model: returns bytes on its own lanes, marker 0xEE elsewhere
    always_comb begin
        bus_rdata = 32'hEEEE_EEEE;
        for (int l = 0; l < 4; l++) begin
            if (l < cur_w) begin
                logic [7:0] a;
                a = (bus_addr[7:0] & ~8'(cur_w - 1)) + 8'(cur_big ? (cur_w - 1 - l) : l);
                bus_rdata[l*8 +: 8] = mem[a];
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one access; step/lane/data expectations follow R2..R9
    task automatic run_access(input logic [1:0] sz, input logic [1:0] wc, input bit big,
                              input logic [7:0] addr, input logic [31:0] wd, input bit wr,
                              input bit intrude);
        int nb, w, s, beats;
        logic [31:0] exp_rd;
        nb = 1 << sz; w = 1 << wc; s = (nb < w) ? nb : w; beats = nb / s;
        cur_w = w; cur_big = big;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_size = sz; req_addr = AW'(addr);
        req_wdata = wd; big_end = big; dev_width = wc;
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < beats; i++) begin
            logic [3:0] e_en;
            logic [31:0] e_wd;
            e_en = '0; e_wd = '0;
            for (int k = 0; k < s; k++) begin
                int a, j, sig, lane;
                a = addr + i*s + k; j = i*s + k;
                sig = big ? nb - 1 - j : j;
                lane = big ? w - 1 - (a % w) : a % w;
                e_en[lane] = 1'b1;
                if (wr) e_wd[lane*8 +: 8] = wd[sig*8 +: 8];
            end
            if (i == 0) begin first_en = lane_en; first_wd = bus_wdata; end
            check("R2 bus_valid during beat", 32'(bus_valid), 32'd1);
            check("R3 beat address", bus_addr, 32'(addr) + 32'(i*s));
            check("R9 lane strobes", 32'(lane_en), 32'(e_en));
            check("R7 lane write data", bus_wdata, e_wd);
            check("R7 write flag", 32'(bus_write), 32'(wr));
            if (intrude && i == 0) begin
                req_valid = 1; req_addr = AW'(addr) + 32'h40; req_size = 2'd1; req_write = ~wr;
            end
            if (intrude && i == 1) req_valid = 0;
            @(negedge clk);
        end
        req_valid = 0;
        check("R8 done pulse", 32'(done), 32'd1);
        check("R2 bus idle after last beat", 32'(bus_valid), 32'd0);
        if (!wr) begin
            exp_rd = '0;
            for (int b = 0; b < nb; b++)
                exp_rd[b*8 +: 8] = mem[8'(addr + (big ? nb - 1 - b : b))];
            check("R8 assembled read", rdata, exp_rd);
        end
        @(negedge clk);
        check("R8 done one cycle", 32'(done), 32'd0);
        if (intrude) begin
            check("R11 no extra bus cycle", 32'(bus_valid), 32'd0);
            check("R11 no error", 32'(err), 32'd0);
        end
    endtask

    task automatic t_reset();
        check("R10 ready", 32'(req_ready), 32'd1);
        check("R10 bus_valid", 32'(bus_valid), 32'd0);
        check("R10 done/err", {30'd0, done, err}, 32'd0);
        check("R10 strobes", 32'(lane_en), 32'd0);
        check("R10 rdata", rdata, 32'd0);
    endtask

    task automatic t_big32();
        for (int o = 0; o < 4; o++) begin
            run_access(2'd0, 2'd2, 1, 8'(16 + o), 32'h0000_005A, 1, 0);
            check("R4 BE byte lane", 32'(first_en), 32'(4'b1000 >> o));
        end
        run_access(2'd1, 2'd2, 1, 8'd20, 32'h0000_A1B2, 1, 0);
        check("R4 BE word@0 data", first_wd, 32'hA1B2_0000);
        run_access(2'd1, 2'd2, 1, 8'd22, 32'h0000_A1B2, 1, 0);
        check("R4 BE word@2 data", first_wd, 32'h0000_A1B2);
        run_access(2'd2, 2'd2, 1, 8'd24, 32'h1122_3344, 1, 0);
        check("R4 BE long data", first_wd, 32'h1122_3344);
    endtask

    task automatic t_little32();
        for (int o = 0; o < 4; o++) begin
            run_access(2'd0, 2'd2, 0, 8'(32 + o), 32'h0000_00C3, 1, 0);
            check("R5 LE byte lane", 32'(first_en), 32'(4'b0001 << o));
        end
        run_access(2'd1, 2'd2, 0, 8'd34, 32'h0000_A1B2, 1, 0);
        check("R5 LE word@2 data", first_wd, 32'hA1B2_0000);
        run_access(2'd2, 2'd2, 0, 8'd36, 32'h1122_3344, 1, 0);
        check("R5 LE long data", first_wd, 32'h1122_3344);
    endtask

    task automatic t_narrow();
        run_access(2'd2, 2'd0, 1, 8'd40, 32'hDEAD_BEEF, 1, 0);
        check("R6 8-bit BE first byte", first_wd, 32'h0000_00DE);
        run_access(2'd2, 2'd0, 0, 8'd44, 32'hDEAD_BEEF, 1, 0);
        check("R6 8-bit LE first byte", first_wd, 32'h0000_00EF);
        run_access(2'd2, 2'd1, 1, 8'd48, 32'hCAFE_F00D, 1, 0);
        check("R6 16-bit BE first half", first_wd, 32'h0000_CAFE);
        run_access(2'd2, 2'd1, 0, 8'd52, 32'hCAFE_F00D, 1, 0);
        check("R6 16-bit LE first half", first_wd, 32'h0000_F00D);
        run_access(2'd0, 2'd1, 1, 8'd57, 32'h0000_0077, 1, 0);
        check("R6 16-bit BE odd byte lane", 32'(first_en), 32'b0001);
        run_access(2'd1, 2'd0, 0, 8'd58, 32'h0000_1234, 1, 0);
    endtask

    task automatic t_reads();
        for (int wc = 0; wc < 3; wc++) begin
            run_access(2'd2, 2'(wc), 1, 8'd64, 32'h0, 0, 0);
            run_access(2'd2, 2'(wc), 0, 8'd68, 32'h0, 0, 0);
            run_access(2'd1, 2'(wc), 1, 8'd74, 32'h0, 0, 0);
            run_access(2'd0, 2'(wc), 0, 8'd79, 32'h0, 0, 0);
        end
    endtask

    task automatic t_reject(input logic [1:0] sz, input logic [1:0] wc, input logic [7:0] addr);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_size = sz; req_addr = AW'(addr);
        req_wdata = 32'hFFFF_FFFF; big_end = 1; dev_width = wc;
        @(negedge clk);
        req_valid = 0;
        check("R1 err pulse", 32'(err), 32'd1);
        check("R1 no bus cycle", 32'(bus_valid), 32'd0);
        check("R1 no done", 32'(done), 32'd0);
        @(negedge clk);
        check("R1 err one cycle", 32'(err), 32'd0);
        check("R1 still idle", 32'(bus_valid), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_big32();
        t_little32();
        t_narrow();
        t_reads();
        t_reject(2'd1, 2'd2, 8'd3);
        t_reject(2'd2, 2'd1, 8'd6);
        t_reject(2'd3, 2'd2, 8'd0);
        t_reject(2'd0, 2'd3, 8'd0);
        run_access(2'd2, 2'd0, 1, 8'd88, 32'h0, 0, 1);
        run_access(2'd2, 2'd1, 0, 8'd92, 32'h5566_7788, 1, 1);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule